// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear/Toggle Aliases

This block is an eight-pin general-purpose I/O bank behind a 32-bit register bus. It keeps three kinds of state. Each pin has a control word that holds a function-select field. A shared fast I/O region holds the drive values, the output enables and the input level of all pins. Each pin also has a pad word that holds input enable, output disable and pull selection. The pins' drive value, effective output enable, input enable and pull code leave the block as plain vectors.

Software can write every register through four address windows. A write through the first window replaces the register. A write through the second toggles the bits that are 1 in the write data. A write through the third sets those bits, and a write through the fourth clears them. This lets two agents change single bits of a shared register without a read-modify-write race. Reads return the plain register value, whatever window the address falls in.

A pin drives only when three conditions hold together: its fast I/O enable bit is set, its function select routes it to the software I/O path, and its pad output-disable bit is clear. The pad bit always wins.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset, every function select reads 31 (0x1F), and every pad word reads 0xC0 (output disable at bit 7 set, input enable at bit 6 set, pull 0). The fast I/O registers read 0, `pin_oe` and `pin_out` are 0, `pin_ie` is all ones and `pin_pull` is 0.
- R2: A bus address is split as follows. Bits 17:16 give the region: 0 is control, 1 is fast I/O, 2 is pads. Bits 13:12 give the window. Bits 11:0 give the offset, and bits 15:14 must be 0. A plain write (window 0) replaces the addressed register. The control word of pin p sits at offset 0x004+8p and keeps only bits 4:0. The pad word of pin p sits at offset 0x04+4p and keeps only bits 7, 6, 3 and 2. In the fast I/O region, offset 0x00 is the output value and 0x04 is the output enable, one bit per pin.
- R3: A write through window 1 (+0x1000) XORs the write data into the register.
- R4: A write through window 2 (+0x2000) ORs the write data into the register.
- R5: A write through window 3 (+0x3000) clears the register bits where the write data is 1.
- R6: A read through any of the four windows returns the plain register value, one cycle after the read strobe.
- R7: `pin_oe[p]` is 1 only when three things hold: fast I/O enable bit p is 1, the function select of pin p equals 5, and pad output disable of pin p is 0. Output disable overrides the enable.
- R8: `pin_out` follows the fast I/O output value register.
- R9: The fast I/O input register (offset 0x08) reads `pin_in` after a two-flop synchroniser, ANDed with each pin's input enable. Writes to it through any window have no effect.
- R10: Pad bit 6 drives `pin_ie[p]`. Pad bits 3:2 drive `pin_pull[2p+1:2p]`, where 0 is off, 1 is pull-down and 2 is pull-up.
- R11: A write to an address that maps to no register changes nothing, and a read from such an address returns 0. This covers an offset that is not a word of the region, a pin index of 8 or more, and region 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | 18 | Byte address: region, window and offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd_en` |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin effective output enable |
| pin_ie | output | 8 | Per-pin input enable |
| pin_pull | output | 16 | Two-bit pull code per pin |

## Verification
The window logic is tried on each region with three kinds of write data: data that overlaps the stored bits, data that is disjoint from them, and data with junk in the unkept bit positions. A wrong merge operator or a missing storage mask then gives a different readback. Reads go through non-zero windows so that reads which decode the window can be told from reads which ignore it.

The output-enable path is walked through all combinations that matter. A pin whose function select is not 5 must stay undriven. A pin with function select 5 must drive or not as its pad disable bit is cleared and set again. The input path uses patterns in which a disabled pin is driven high, which exposes a missing input-enable mask. Writes to the read-only input register and to unmapped or out-of-range addresses are followed by readbacks that show no state moved.

// File: rtl/gpio_bank_pkg.sv
// Shared types and helpers for the aliased GPIO bank.
// Assumes a 32-bit data bus. The window code is taken from address bits 13:12.
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        WIN_PLAIN = 2'd0,
        WIN_TOGGLE = 2'd1,
        WIN_SET = 2'd2,
        WIN_CLEAR = 2'd3
    } win_e;

    localparam logic [4:0] FSEL_NONE = 5'd31;
    localparam logic [4:0] FSEL_SWIO = 5'd5;

    // Merge write data into an old register value according to the window
    function automatic logic [31:0] win_merge(win_e w, logic [31:0] old_v, logic [31:0] wd);
        case (w)
            WIN_PLAIN:  win_merge = wd;
            WIN_TOGGLE: win_merge = old_v ^ wd;
            WIN_SET:    win_merge = old_v | wd;
            default:    win_merge = old_v & ~wd;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
// Address decoder: splits a byte address into region, window and register,
// and raises exactly one hit flag or none. Assumes ADDR_W >= 18.
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int ADDR_W = 18,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic              ctrl_hit,
    output logic              pad_hit,
    output logic              fout_hit,
    output logic              foe_hit,
    output logic              fin_hit,
    output logic [PIN_W-1:0]  pin_idx
);
    logic [1:0]  region;
    logic [11:0] offs;
    logic        gap_ok;
    logic [8:0]  ctrl_slot;
    logic [9:0]  pad_slot;
    logic [9:0]  pad_pin;

    // Field extraction and per-region word matching
    always_comb begin
        region    = addr[17:16];
        offs      = addr[11:0];
        win       = win_e'(addr[13:12]);
        gap_ok    = (addr[15:14] == 2'b00) && (ADDR_W == 18 || addr[ADDR_W-1:18 % ADDR_W] == '0 || ADDR_W <= 18);
        ctrl_slot = offs[11:3];
        pad_slot  = offs[11:2];
        pad_pin   = pad_slot - 10'd1;
        ctrl_hit  = gap_ok && region == 2'd0 && offs[2:0] == 3'b100
                    && ctrl_slot < 9'(NPINS);
        pad_hit   = gap_ok && region == 2'd2 && offs[1:0] == 2'b00
                    && pad_slot != 10'd0 && pad_pin < 10'(NPINS);
        fout_hit  = gap_ok && region == 2'd1 && offs == 12'h000;
        foe_hit   = gap_ok && region == 2'd1 && offs == 12'h004;
        fin_hit   = gap_ok && region == 2'd1 && offs == 12'h008;
        pin_idx   = ctrl_hit ? ctrl_slot[PIN_W-1:0] : pad_pin[PIN_W-1:0];
    end

endmodule

// File: rtl/gpio_bank_pincfg.sv
// Per-pin control and pad storage. Each write goes through the window merge.
// Assumes at most one of ctrl_hit/pad_hit per cycle (the decoder guarantees it).
module gpio_bank_pincfg
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               ctrl_hit,
    input  logic               pad_hit,
    input  win_e               win,
    input  logic [PIN_W-1:0]   pin_idx,
    input  logic [31:0]        wdata,
    output logic [5*NPINS-1:0] fsel_flat,
    output logic [NPINS-1:0]   pad_od,
    output logic [NPINS-1:0]   pad_ie,
    output logic [2*NPINS-1:0] pad_pull,
    output logic [31:0]        ctrl_word,
    output logic [31:0]        pad_word
);
    logic [31:0] ctrl_img [NPINS];
    logic [31:0] pad_img  [NPINS];

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [4:0]  fsel_q;
        logic        od_q;
        logic        ie_q;
        logic [1:0]  pull_q;
        logic [31:0] ctrl_new;
        logic [31:0] pad_new;
        logic        sel_c;
        logic        sel_p;

        // Build register images and their merged next values
        always_comb begin
            ctrl_img[p] = {27'd0, fsel_q};
            pad_img[p]  = {24'd0, od_q, ie_q, 2'b00, pull_q, 2'b00};
            ctrl_new    = win_merge(win, ctrl_img[p], wdata);
            pad_new     = win_merge(win, pad_img[p], wdata);
            sel_c       = wr_en && ctrl_hit && pin_idx == PIN_W'(p);
            sel_p       = wr_en && pad_hit && pin_idx == PIN_W'(p);
        end

        // Function-select register for this pin
        always_ff @(posedge clk) begin
            if (!rst_n) fsel_q <= FSEL_NONE;
            else if (sel_c) fsel_q <= ctrl_new[4:0];
        end

        // Pad configuration register for this pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                od_q   <= 1'b1;
                ie_q   <= 1'b1;
                pull_q <= 2'b00;
            end else if (sel_p) begin
                od_q   <= pad_new[7];
                ie_q   <= pad_new[6];
                pull_q <= pad_new[3:2];
            end
        end

        assign fsel_flat[5*p +: 5] = fsel_q;
        assign pad_od[p]           = od_q;
        assign pad_ie[p]           = ie_q;
        assign pad_pull[2*p +: 2]  = pull_q;
    end

    // Readback of the addressed pin's words
    always_comb begin
        ctrl_word = ctrl_img[pin_idx];
        pad_word  = pad_img[pin_idx];
    end

endmodule

// File: rtl/gpio_bank_insync.sv
// Two-flop synchroniser for the pin inputs, followed by the input-enable mask.
// Assumes pin_in is asynchronous to clk. The level is valid two edges after a change.
module gpio_bank_insync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] in_en,
    output logic [NPINS-1:0] level
);
    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;

    // Two-stage capture of the raw pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    assign level = sync_q & in_en;

endmodule

// File: rtl/gpio_alias_bank.sv
// Top of the aliased GPIO bank: decoder, per-pin configuration, fast I/O
// registers, output-enable arbitration and registered read mux.
// Assumes single-cycle strobes; a write and a read are never issued together.
module gpio_alias_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int ADDR_W = 18,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    output logic [NPINS-1:0]   pin_ie,
    output logic [2*NPINS-1:0] pin_pull
);
    win_e               win;
    logic               ctrl_hit, pad_hit, fout_hit, foe_hit, fin_hit;
    logic [PIN_W-1:0]   pin_idx;
    logic [5*NPINS-1:0] fsel_flat;
    logic [NPINS-1:0]   pad_od;
    logic [NPINS-1:0]   pad_ie;
    logic [31:0]        ctrl_word, pad_word;
    logic [NPINS-1:0]   in_level;
    logic [NPINS-1:0]   fout_q, foe_q;
    logic [NPINS-1:0]   swio_sel;
    logic [31:0]        fout_new, foe_new, rd_mux;

    gpio_bank_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dec_i (
        .addr(bus_addr), .win(win), .ctrl_hit(ctrl_hit), .pad_hit(pad_hit),
        .fout_hit(fout_hit), .foe_hit(foe_hit), .fin_hit(fin_hit), .pin_idx(pin_idx)
    );

    gpio_bank_pincfg #(.NPINS(NPINS)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .ctrl_hit(ctrl_hit),
        .pad_hit(pad_hit), .win(win), .pin_idx(pin_idx), .wdata(bus_wdata),
        .fsel_flat(fsel_flat), .pad_od(pad_od), .pad_ie(pad_ie),
        .pad_pull(pin_pull), .ctrl_word(ctrl_word), .pad_word(pad_word)
    );

    gpio_bank_insync #(.NPINS(NPINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .in_en(pad_ie), .level(in_level)
    );

    // Merged next values of the writable fast I/O registers
    always_comb begin
        fout_new = win_merge(win, 32'(fout_q), bus_wdata);
        foe_new  = win_merge(win, 32'(foe_q), bus_wdata);
    end

    // Fast I/O output value and output enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fout_q <= '0;
            foe_q  <= '0;
        end else if (bus_wr_en) begin
            if (fout_hit) fout_q <= fout_new[NPINS-1:0];
            if (foe_hit)  foe_q  <= foe_new[NPINS-1:0];
        end
    end

    // Pins routed to the software I/O path
    for (genvar p = 0; p < NPINS; p++) begin : g_route
        assign swio_sel[p] = (fsel_flat[5*p +: 5] == FSEL_SWIO);
    end

    // Output-enable arbitration: the pad disable bit overrides everything
    always_comb begin
        pin_oe  = foe_q & swio_sel & ~pad_od;
        pin_out = fout_q;
        pin_ie  = pad_ie;
    end

    // Read selection; the window bits are ignored for reads
    always_comb begin
        rd_mux = '0;
        if (ctrl_hit)      rd_mux = ctrl_word;
        else if (pad_hit)  rd_mux = pad_word;
        else if (fout_hit) rd_mux = 32'(fout_q);
        else if (foe_hit)  rd_mux = 32'(foe_q);
        else if (fin_hit)  rd_mux = 32'(in_level);
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_alias_bank_chk.sv
// Checker for the aliased GPIO bank, bound into the top module.
// It observes ports and the per-pin configuration and input-level signals.
module gpio_alias_bank_chk #(
    parameter int NPINS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_en,
    input logic [NPINS-1:0]   pin_in,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe,
    input logic [NPINS-1:0]   pin_ie,
    input logic [5*NPINS-1:0] fsel_flat,
    input logic [NPINS-1:0]   od_vec,
    input logic [NPINS-1:0]   in_level
);
    logic [NPINS-1:0] is_swio;
    logic [1:0]       settle;

    for (genvar p = 0; p < NPINS; p++) begin : g_sel
        assign is_swio[p] = (fsel_flat[5*p +: 5] == 5'd5);
    end

    // Count cycles since reset so that synchroniser history is valid
    always_ff @(posedge clk) begin
        if (!rst_n) settle <= 2'd0;
        else if (settle != 2'd3) settle <= settle + 2'd1;
    end

    a_r7_oe_needs_swio: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~is_swio) == '0);

    a_r7_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & od_vec) == '0);

    a_r9_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (in_level & ~pin_ie) == '0);

    a_r9_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (settle >= 2'd2) |-> (in_level == ($past(pin_in, 2) & pin_ie)));

    a_r8_out_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr_en) |-> $stable(pin_out));

endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(.NPINS(NPINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie),
    .fsel_flat(fsel_flat), .od_vec(pad_od), .in_level(in_level)
);

// File: tb/gpio_alias_bank_tb.sv
`timescale 1ns/1ps
module gpio_alias_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, pin_ie;
    logic [15:0] pin_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_alias_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie),
        .pin_pull(pin_pull)
    );

    typedef struct packed {
        logic        rd;
        logic [3:0]  req;
        logic [17:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1,  18'h00004, 32'h1F},       // R1 ctrl reset
        '{1'b1, 4'd1,  18'h2000C, 32'hC0},       // R1 pad reset
        '{1'b1, 4'd1,  18'h10004, 32'h00},       // R1 oe reset
        '{1'b0, 4'd2,  18'h00004, 32'hFFFFFFE5}, // R2 plain ctrl, junk high bits
        '{1'b1, 4'd2,  18'h00004, 32'h05},
        '{1'b0, 4'd2,  18'h20004, 32'hFFFFFF48}, // R2 plain pad
        '{1'b1, 4'd2,  18'h20004, 32'h48},
        '{1'b0, 4'd3,  18'h21004, 32'h0C},       // R3 toggle pad pull
        '{1'b1, 4'd3,  18'h20004, 32'h44},
        '{1'b0, 4'd3,  18'h01004, 32'h01},       // R3 toggle ctrl
        '{1'b1, 4'd3,  18'h00004, 32'h04},
        '{1'b0, 4'd3,  18'h01004, 32'h01},
        '{1'b0, 4'd4,  18'h12004, 32'h05},       // R4 set oe
        '{1'b1, 4'd4,  18'h10004, 32'h05},
        '{1'b0, 4'd4,  18'h12004, 32'h02},
        '{1'b1, 4'd4,  18'h10004, 32'h07},
        '{1'b0, 4'd5,  18'h13004, 32'h04},       // R5 clear oe
        '{1'b1, 4'd5,  18'h10004, 32'h03},
        '{1'b0, 4'd5,  18'h23004, 32'h40},       // R5 clear pad ie
        '{1'b1, 4'd5,  18'h20004, 32'h04},
        '{1'b1, 4'd6,  18'h21004, 32'h04},       // R6 read via windows
        '{1'b1, 4'd6,  18'h03004, 32'h05},
        '{1'b1, 4'd6,  18'h12004, 32'h03},
        '{1'b0, 4'd2,  18'h10000, 32'hA5},       // R2 output value
        '{1'b1, 4'd2,  18'h10000, 32'hA5},
        '{1'b0, 4'd11, 18'h00008, 32'h1F},       // R11 non-word offset
        '{1'b1, 4'd11, 18'h00008, 32'h00},
        '{1'b1, 4'd11, 18'h00004, 32'h05},
        '{1'b0, 4'd11, 18'h30004, 32'hFF},       // R11 region 3
        '{1'b1, 4'd11, 18'h30004, 32'h00},
        '{1'b1, 4'd1,  18'h20020, 32'hC0},       // R1 last pad word
        '{1'b1, 4'd11, 18'h20024, 32'h00}        // R11 pin index 8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [17:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [17:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 pin-level reset state
        check("R1 oe", 32'(pin_oe), 32'h0);
        check("R1 ie", 32'(pin_ie), 32'hFF);
        check("R1 pull", 32'(pin_pull), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].data);
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R8 drive value follows output register
        check("R8 out", 32'(pin_out), 32'hA5);
        // R7 pin0 routed and enabled, pin1 not routed
        check("R7 base", 32'(pin_oe), 32'h01);
        bus_write(18'h0000C, 32'h5);
        check("R7 disable holds", 32'(pin_oe), 32'h01);
        bus_write(18'h23008, 32'h80);
        check("R7 enabled", 32'(pin_oe), 32'h03);
        bus_write(18'h22008, 32'h80);
        check("R7 override", 32'(pin_oe), 32'h01);

        // R10 pad bits to pin outputs
        check("R10 ie", 32'(pin_ie), 32'hFE);
        check("R10 pull0", 32'(pin_pull), 32'h0001);
        bus_write(18'h20010, 32'hC8);
        check("R10 pull3", 32'(pin_pull), 32'h0081);

        // R9 synchronised and masked input level
        @(negedge clk); pin_in = 8'hFF;
        repeat (3) @(negedge clk);
        bus_read(18'h10008, rd);
        check("R9 masked", rd, 32'hFE);
        bus_write(18'h11008, 32'hFF);
        bus_write(18'h12008, 32'hFF);
        bus_read(18'h10008, rd);
        check("R9 write ignored", rd, 32'hFE);
        @(negedge clk); pin_in = 8'h5A;
        repeat (3) @(negedge clk);
        bus_read(18'h13008, rd);
        check("R9 pattern", rd, 32'h5A);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 oe after reset", 32'(pin_oe), 32'h0);
        check("R1 out after reset", 32'(pin_out), 32'h0);
        check("R1 ie after reset", 32'(pin_ie), 32'hFF);
        bus_read(18'h00004, rd);
        check("R1 fsel after reset", rd, 32'h1F);

        finish_run();
    end

endmodule